// File: doc/BRIEF.md
# Table-Driven Waveform Address Sequencer

This block plays a stored waveform out of a 512-entry sample table. On each update it reads the entry at its current table address and presents it as a 12-bit converter code. It then moves the address inside a window set by a first and a last address. The step is either one or one of three shared step values. A pacing prescaler and a per-code hold counter set how fast the updates come. A strobe marks every new code, and a separate pulse marks the final code of a one-shot playback.

The shape of the playback depends on the mode. A ramp climbs from the first address to the last. A triangle climbs and then descends back. A full-wave pattern runs the triangle twice and inverts the second pair of half-waves. In two further modes the table is bypassed: an external address picks the table entry, or an external code is sent straight to the output. The table storage sits outside the block. The block drives the table read address and takes back the sample with an asynchronous read in the same cycle. The settings belong to the one channel being served. They must stay constant while `enable` is high.

Top module: `lut_wave_sequencer`

## Requirements
- R1: After reset `dacCode` is 0 and `codeStrobe` and `donePulse` are low.
- R2: `codeStrobe` pulses once every (clkDiv+1)*(sampleTime+1) clock cycles while enabled and not finished, and `dacCode` changes only in a cycle where `codeStrobe` is high.
- R3: `stepSel` 0 gives a step of 1. Values 1, 2 and 3 take `stepVal0`, `stepVal1` and `stepVal2`. A step that would carry the address past the end of the window is clamped to that end.
- R4: Ramp modes (`opMode` 0 one-shot, 3 looping) output the entries from `startAddr` up to `endAddr`. The looping ramp then restarts at `startAddr`.
- R5: Triangle modes (`opMode` 1 one-shot, 4 looping) climb to `endAddr` and then step back down to `startAddr`. Each turning-point entry is output only once. The looping triangle then climbs again.
- R6: Full-wave modes (`opMode` 2 one-shot, 5 looping) play two triangles and invert the second one. With `signedMode` low, inversion gives 4095 minus the value. With `signedMode` high, the value is negated as two's complement, and 0x800 saturates to 0x7FF.
- R7: In the one-shot modes (`opMode` 0 to 2), `donePulse` is high for one cycle together with the strobe of the final code. No strobe follows, and `dacCode` holds that code until `enable` drops.
- R8: With `opMode` 6, `lutAddr` follows `extAddr`, and every update loads the addressed table entry without inversion.
- R9: With `opMode` 7, every update loads `extData` unchanged, even when `signedMode` is high.
- R10: While `enable` is low no strobe is issued. Raising `enable` again restarts playback at `startAddr` in the rising phase.
- R11: In the table modes (`opMode` 0 to 5), `lutAddr` stays within [`startAddr`, `endAddr`] from the cycle after playback starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel run request |
| startAddr | input | 9 | First table address of the window |
| endAddr | input | 9 | Last table address of the window, not below startAddr |
| opMode | input | 3 | Playback mode (encodings in R4 to R9) |
| stepSel | input | 2 | Step choice (encoding in R3) |
| stepVal0 | input | 9 | Shared step value 0 |
| stepVal1 | input | 9 | Shared step value 1 |
| stepVal2 | input | 9 | Shared step value 2 |
| clkDiv | input | 10 | Pacing prescaler setting, divide by value+1 |
| sampleTime | input | 8 | Prescaled ticks per code, minus one |
| signedMode | input | 1 | Treat table samples as two's complement |
| extAddr | input | 9 | External table address for mode 6 |
| extData | input | 12 | External code for mode 7 |
| lutAddr | output | 9 | Table read address |
| lutData | input | 12 | Table sample at lutAddr, same cycle |
| dacCode | output | 12 | Converter code |
| codeStrobe | output | 1 | One-cycle marker of a new code |
| donePulse | output | 1 | One-cycle marker of the final one-shot code |

## Verification
Some properties are checked on every cycle. No strobe may appear while the channel is off. The code may change only together with a strobe. Strobes may never come back to back when the pacing is slower than one clock. The done pulse lasts one cycle, always comes with a strobe, and only in one-shot modes. The table address stays inside the window. Other behaviour can only be shown by the scenarios, which compare the exact code order against a model of the rules. That covers the turning points, the clamp at the window end, the choice of step register, unsigned and signed inversion including the saturated minimum, the exact pacing interval, the code held after one-shot completion, and the restart after `enable` is dropped.

// File: rtl/lut_wave_sequencer_pkg.sv
package lut_wave_sequencer_pkg;

  typedef enum logic [2:0] {
    MODE_ONCE_RAMP = 3'd0,
    MODE_ONCE_TRI  = 3'd1,
    MODE_ONCE_FULL = 3'd2,
    MODE_LOOP_RAMP = 3'd3,
    MODE_LOOP_TRI  = 3'd4,
    MODE_LOOP_FULL = 3'd5,
    MODE_EXT_ADDR  = 3'd6,
    MODE_EXT_DATA  = 3'd7
  } playMode_e;

  // bit 0: descending, bit 1: inverted half
  typedef enum logic [1:0] {
    PH_UP       = 2'd0,
    PH_DOWN     = 2'd1,
    PH_UP_INV   = 2'd2,
    PH_DOWN_INV = 2'd3
  } phase_e;

  typedef struct packed {
    logic load;      // latch a new code this cycle
    logic invert;    // current sample belongs to an inverted half
    logic finish;    // this code ends a one-shot playback
    logic passData;  // take the external code instead of the table
  } seqStrobe_t;

endpackage

// File: rtl/lut_wave_seq_ctrl.sv
module lut_wave_seq_ctrl
  import lut_wave_sequencer_pkg::*;
#(
  parameter int AddrW = 9,
  parameter int DivW  = 10,
  parameter int SmpW  = 8,
  parameter int NumStepRegs = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               enable,
  input  logic [AddrW-1:0]                   startAddr,
  input  logic [AddrW-1:0]                   endAddr,
  input  logic [2:0]                         opMode,
  input  logic [1:0]                         stepSel,
  input  logic [NumStepRegs-1:0][AddrW-1:0]  stepRegs,
  input  logic [DivW-1:0]                    clkDiv,
  input  logic [SmpW-1:0]                    sampleTime,
  input  logic [AddrW-1:0]                   extAddr,
  output logic [AddrW-1:0]                   lutAddr,
  output seqStrobe_t                         strb
);

  localparam logic [AddrW-1:0] UnitStep = AddrW'(1);

  playMode_e         mode;
  phase_e            phase, nextPhase;
  logic              active, finished, finishNow;
  logic [DivW-1:0]   divCnt;
  logic [SmpW-1:0]   smpCnt;
  logic [AddrW-1:0]  addr, nextAddr, stepSize, fwdNext, revNext, revGap;
  logic [AddrW:0]    fwdSum;
  logic              tick, update, isOneShot, isRamp, isFull, isExt;

  assign mode = playMode_e'(opMode);

  assign isOneShot = (mode == MODE_ONCE_RAMP) || (mode == MODE_ONCE_TRI) || (mode == MODE_ONCE_FULL);
  assign isRamp    = (mode == MODE_ONCE_RAMP) || (mode == MODE_LOOP_RAMP);
  assign isFull    = (mode == MODE_ONCE_FULL) || (mode == MODE_LOOP_FULL);
  assign isExt     = (mode == MODE_EXT_ADDR)  || (mode == MODE_EXT_DATA);

  always_comb begin
    stepSize = UnitStep;
    for (int k = 0; k < NumStepRegs; k++) begin
      if (int'(stepSel) == k + 1) stepSize = stepRegs[k];
    end
  end

  // clamped moves inside the window
  assign fwdSum  = {1'b0, addr} + {1'b0, stepSize};
  assign fwdNext = (fwdSum > {1'b0, endAddr}) ? endAddr : fwdSum[AddrW-1:0];
  assign revGap  = addr - startAddr;
  assign revNext = (revGap < stepSize) ? startAddr : addr - stepSize;

  assign tick   = active && enable && (divCnt == clkDiv);
  assign update = tick && (smpCnt == sampleTime) && !finished;

  always_comb begin
    nextAddr  = addr;
    nextPhase = phase;
    finishNow = 1'b0;
    if (!isExt) begin
      if (!phase[0]) begin
        if (addr == endAddr) begin
          if (isRamp) begin
            if (isOneShot) finishNow = 1'b1;
            else           nextAddr  = startAddr;
          end else begin
            nextPhase = phase_e'({phase[1], 1'b1});
            nextAddr  = revNext;
          end
        end else begin
          nextAddr = fwdNext;
        end
      end else begin
        if (addr == startAddr) begin
          if (isFull && !phase[1]) begin
            nextPhase = PH_UP_INV;
            nextAddr  = fwdNext;
          end else if (isOneShot) begin
            finishNow = 1'b1;
          end else begin
            nextPhase = PH_UP;
            nextAddr  = fwdNext;
          end
        end else begin
          nextAddr = revNext;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      finished <= 1'b0;
      divCnt   <= '0;
      smpCnt   <= '0;
      addr     <= '0;
      phase    <= PH_UP;
    end else if (!enable) begin
      active   <= 1'b0;
      finished <= 1'b0;
      divCnt   <= '0;
      smpCnt   <= '0;
    end else if (!active) begin
      active   <= 1'b1;
      finished <= 1'b0;
      divCnt   <= '0;
      smpCnt   <= '0;
      addr     <= startAddr;
      phase    <= PH_UP;
    end else begin
      if (divCnt == clkDiv) begin
        divCnt <= '0;
        smpCnt <= (smpCnt == sampleTime) ? '0 : smpCnt + SmpW'(1);
      end else begin
        divCnt <= divCnt + DivW'(1);
      end
      if (update) begin
        addr  <= nextAddr;
        phase <= nextPhase;
        if (finishNow) finished <= 1'b1;
      end
    end
  end

  assign lutAddr       = (mode == MODE_EXT_ADDR) ? extAddr : addr;
  assign strb.load     = update;
  assign strb.invert   = phase[1];
  assign strb.finish   = update && finishNow;
  assign strb.passData = (mode == MODE_EXT_DATA);

endmodule

// File: rtl/lut_wave_seq_datapath.sv
module lut_wave_seq_datapath
  import lut_wave_sequencer_pkg::*;
#(
  parameter int CodeW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             signedMode,
  input  logic [CodeW-1:0] lutData,
  input  logic [CodeW-1:0] extData,
  output logic [CodeW-1:0] dacCode,
  output logic             codeStrobe,
  output logic             donePulse
);

  localparam logic [CodeW-1:0] MinSigned = {1'b1, {(CodeW-1){1'b0}}};

  logic [CodeW-1:0] inverted, nextCode;

  always_comb begin
    if (signedMode) inverted = (lutData == MinSigned) ? ~MinSigned : ~lutData + CodeW'(1);
    else            inverted = ~lutData;
  end

  always_comb begin
    if (strb.passData)    nextCode = extData;
    else if (strb.invert) nextCode = inverted;
    else                  nextCode = lutData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode    <= '0;
      codeStrobe <= 1'b0;
      donePulse  <= 1'b0;
    end else begin
      codeStrobe <= strb.load;
      donePulse  <= strb.finish;
      if (strb.load) dacCode <= nextCode;
    end
  end

endmodule

// File: rtl/lut_wave_sequencer.sv
module lut_wave_sequencer
  import lut_wave_sequencer_pkg::*;
#(
  parameter int AddrW = 9,
  parameter int CodeW = 12,
  parameter int DivW  = 10,
  parameter int SmpW  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [AddrW-1:0] startAddr,
  input  logic [AddrW-1:0] endAddr,
  input  logic [2:0]       opMode,
  input  logic [1:0]       stepSel,
  input  logic [AddrW-1:0] stepVal0,
  input  logic [AddrW-1:0] stepVal1,
  input  logic [AddrW-1:0] stepVal2,
  input  logic [DivW-1:0]  clkDiv,
  input  logic [SmpW-1:0]  sampleTime,
  input  logic             signedMode,
  input  logic [AddrW-1:0] extAddr,
  input  logic [CodeW-1:0] extData,
  output logic [AddrW-1:0] lutAddr,
  input  logic [CodeW-1:0] lutData,
  output logic [CodeW-1:0] dacCode,
  output logic             codeStrobe,
  output logic             donePulse
);

  localparam int NumStepRegs = 3;

  logic [NumStepRegs-1:0][AddrW-1:0] stepRegs;
  seqStrobe_t strb;

  assign stepRegs = {stepVal2, stepVal1, stepVal0};

  lut_wave_seq_ctrl #(
    .AddrW(AddrW), .DivW(DivW), .SmpW(SmpW), .NumStepRegs(NumStepRegs)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .startAddr(startAddr), .endAddr(endAddr), .opMode(opMode),
    .stepSel(stepSel), .stepRegs(stepRegs),
    .clkDiv(clkDiv), .sampleTime(sampleTime), .extAddr(extAddr),
    .lutAddr(lutAddr), .strb(strb)
  );

  lut_wave_seq_datapath #(.CodeW(CodeW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .signedMode(signedMode),
    .lutData(lutData), .extData(extData),
    .dacCode(dacCode), .codeStrobe(codeStrobe), .donePulse(donePulse)
  );

endmodule

// File: rtl/lut_wave_sequencer_chk.sv
module lut_wave_sequencer_chk #(
  parameter int AddrW = 9,
  parameter int CodeW = 12,
  parameter int DivW  = 10,
  parameter int SmpW  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [AddrW-1:0] startAddr,
  input logic [AddrW-1:0] endAddr,
  input logic [2:0]       opMode,
  input logic [DivW-1:0]  clkDiv,
  input logic [SmpW-1:0]  sampleTime,
  input logic [AddrW-1:0] lutAddr,
  input logic [CodeW-1:0] dacCode,
  input logic             codeStrobe,
  input logic             donePulse
);

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !codeStrobe);

  assert_code_only_on_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !codeStrobe |-> $stable(dacCode));

  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (codeStrobe && (clkDiv != '0 || sampleTime != '0)) |=> !codeStrobe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  assert_done_with_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> codeStrobe);

  assert_done_oneshot_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> ($past(opMode) < 3'd3));

  assert_addr_in_window_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(enable) && enable && opMode < 3'd6)
      |-> (lutAddr >= startAddr && lutAddr <= endAddr));

endmodule

bind lut_wave_sequencer lut_wave_sequencer_chk #(
  .AddrW(AddrW), .CodeW(CodeW), .DivW(DivW), .SmpW(SmpW)
) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .startAddr(startAddr),
  .endAddr(endAddr), .opMode(opMode), .clkDiv(clkDiv), .sampleTime(sampleTime),
  .lutAddr(lutAddr), .dacCode(dacCode), .codeStrobe(codeStrobe), .donePulse(donePulse)
);

// File: tb/lut_wave_sequencer_tb.sv
module lut_wave_sequencer_tb;

  typedef struct { int code; bit done; } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [8:0]  startAddr = '0, endAddr = '0;
  logic [2:0]  opMode = 3'd3;
  logic [1:0]  stepSel = '0;
  logic [8:0]  stepVal0 = 9'd11, stepVal1 = 9'd13, stepVal2 = 9'd17;
  logic [9:0]  clkDiv = '0;
  logic [7:0]  sampleTime = '0;
  logic        signedMode = 1'b0;
  logic [8:0]  extAddr = '0;
  logic [11:0] extData = '0;
  logic [8:0]  lutAddr;
  logic [11:0] lutData;
  logic [11:0] dacCode;
  logic        codeStrobe, donePulse;

  int checks = 0, errors = 0;
  int cyc = 0, lastCyc = -1, expGap = 1;
  int wStart = 0, wEnd = 511;
  bit winCheck = 0;
  string curReq = "R1";
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  function automatic int lutVal(int a);
    if (a == 40) return 12'h800;
    return (a * 37 + 5) % 4096;
  endfunction

  function automatic int invVal(int d, bit sg);
    if (!sg) return 4095 - d;
    if (d == 2048) return 2047;
    return (4096 - d) % 4096;
  endfunction

  assign lutData = 12'(lutVal(int'(lutAddr)));

  lut_wave_sequencer u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .startAddr(startAddr), .endAddr(endAddr),
    .opMode(opMode), .stepSel(stepSel), .stepVal0(stepVal0), .stepVal1(stepVal1),
    .stepVal2(stepVal2), .clkDiv(clkDiv), .sampleTime(sampleTime), .signedMode(signedMode),
    .extAddr(extAddr), .extData(extData), .lutAddr(lutAddr), .lutData(lutData),
    .dacCode(dacCode), .codeStrobe(codeStrobe), .donePulse(donePulse)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a new code appears
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (codeStrobe) begin
        if (expQ.size() == 0) begin
          chk(1'b0, curReq, "unexpected code strobe", int'(dacCode), -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk(int'(dacCode) == it.code, curReq, "code", int'(dacCode), it.code);
          chk(donePulse == it.done, "R7", "done pulse", int'(donePulse), int'(it.done));
        end
        if (lastCyc >= 0) chk(cyc - lastCyc == expGap, "R2", "strobe interval", cyc - lastCyc, expGap);
        lastCyc = cyc;
        if (winCheck) chk(int'(lutAddr) >= wStart && int'(lutAddr) <= wEnd, "R11", "address in window", int'(lutAddr), wStart);
      end
    end
  end

  // reference playback built from the requirements
  task automatic pushModel(input int s, input int e, input int m, input int step, input bit sg,
                           input int n, output int lastCode, output bit fin);
    int a = s, ph = 0, code;
    bit oneShot = (m < 3), ramp = (m % 3 == 0), full = (m % 3 == 2);
    fin = 0;
    lastCode = 0;
    for (int i = 0; i < n; i++) begin
      expItem_t it;
      code = (ph >= 2) ? invVal(lutVal(a), sg) : lutVal(a);
      if (ph == 0 || ph == 2) begin
        if (a == e) begin
          if (ramp) begin
            if (oneShot) fin = 1; else a = s;
          end else begin
            ph = ph + 1;
            a = (a - step < s) ? s : a - step;
          end
        end else a = (a + step > e) ? e : a + step;
      end else begin
        if (a == s) begin
          if (full && ph == 1) begin ph = 2; a = (a + step > e) ? e : a + step; end
          else if (oneShot) fin = 1;
          else begin ph = 0; a = (a + step > e) ? e : a + step; end
        end else a = (a - step < s) ? s : a - step;
      end
      it.code = code;
      it.done = fin;
      expQ.push_back(it);
      lastCode = code;
      if (fin) break;
    end
  endtask

  task automatic waitDrain(input string req);
    int w = 0;
    while (expQ.size() > 0 && w < 20000) begin @(posedge clk); w++; end
    chk(expQ.size() == 0, req, "items left over", expQ.size(), 0);
  endtask

  task automatic runTable(input int s, input int e, input int m, input int sel, input int stepv,
                          input int div, input int st, input bit sg, input int n, input string req);
    int lastCode;
    bit fin;
    @(negedge clk);
    startAddr = 9'(s); endAddr = 9'(e); opMode = 3'(m); stepSel = 2'(sel);
    stepVal0 = 9'd11; stepVal1 = 9'd13; stepVal2 = 9'd17;
    if (sel == 1) stepVal0 = 9'(stepv);
    if (sel == 2) stepVal1 = 9'(stepv);
    if (sel == 3) stepVal2 = 9'(stepv);
    clkDiv = 10'(div); sampleTime = 8'(st); signedMode = sg;
    curReq = req; expGap = (div + 1) * (st + 1); lastCyc = -1;
    wStart = s; wEnd = e; winCheck = 1;
    pushModel(s, e, m, (sel == 0) ? 1 : stepv, sg, n, lastCode, fin);
    enable = 1'b1;
    waitDrain(req);
    if (fin) begin
      repeat (4 * expGap + 10) @(negedge clk);
      chk(int'(dacCode) == lastCode, "R7", "code held after done", int'(dacCode), lastCode);
    end
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    winCheck = 0;
  endtask

  task automatic runExt(input int m, input int v0, input int v1, input int v2, input int v3, input string req);
    int vals[4];
    vals = '{v0, v1, v2, v3};
    @(negedge clk);
    opMode = 3'(m); clkDiv = 10'd0; sampleTime = 8'd3; signedMode = 1'b1;
    curReq = req; expGap = 4; lastCyc = -1; winCheck = 0;
    for (int i = 0; i < 4; i++) begin
      expItem_t it;
      if (i > 0) begin
        do @(negedge clk); while (!codeStrobe);
      end
      extAddr = 9'(vals[i] % 512);
      extData = 12'(vals[i]);
      it.code = (m == 6) ? lutVal(vals[i] % 512) : vals[i];
      it.done = 0;
      expQ.push_back(it);
      if (i == 0) enable = 1'b1;
      if (m == 6) begin
        #0.5 chk(int'(lutAddr) == vals[i] % 512, "R8", "table address follows input", int'(lutAddr), vals[i] % 512);
      end
    end
    waitDrain(req);
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(dacCode == 12'd0, "R1", "reset code", int'(dacCode), 0);
    chk(codeStrobe == 1'b0, "R1", "reset strobe", int'(codeStrobe), 0);
    chk(donePulse == 1'b0, "R1", "reset done", int'(donePulse), 0);

    runTable(10, 14, 0, 0, 1, 0, 0, 1'b0, 20, "R4");   // one-shot ramp, unit step
    runTable(20, 30, 4, 1, 3, 1, 2, 1'b0, 12, "R5");   // looping triangle, step register 0
    runTable(0, 11, 2, 2, 5, 0, 1, 1'b0, 30, "R6");    // one-shot full wave, unsigned inversion
    runTable(38, 42, 5, 3, 2, 2, 0, 1'b1, 16, "R6");   // looping full wave, signed with 0x800
    runTable(100, 102, 0, 1, 7, 0, 2, 1'b0, 10, "R3"); // step larger than window: clamp
    runTable(50, 60, 3, 0, 1, 1, 0, 1'b0, 3, "R10");   // looping ramp, stopped early
    runTable(50, 60, 3, 0, 1, 1, 0, 1'b0, 2, "R10");   // restart from the first address
    runTable(7, 7, 1, 0, 1, 0, 1, 1'b0, 10, "R5");     // single-entry triangle
    runExt(6, 5, 300, 40, 511, "R8");
    runExt(7, 2048, 4095, 291, 0, "R9");

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule